// File: doc/BRIEF.md
# Memory Alignment Check Unit

This unit watches the stream of memory accesses issued by a processor pipeline and raises an alignment fault whenever an access lands on an address that does not suit its operand size. Each access presents an address, a size code, the privilege level it runs at, and a flag that marks accesses the hardware performs on its own behalf at the most privileged level, such as fetching a descriptor from a table.

Checking is gated by two software-controlled enables: one bit from the flags register and one mask bit from the control register. Both must be set for any fault to be raised. Only accesses at user privilege (level 3) are checked. When a violation is found, the unit produces a one-cycle registered fault pulse and captures the offending address in the same clock edge. The captured address then stays unchanged until the next fault, so the exception logic can read it at any later time.

Top module: `align_guard`

## Requirements
- R1: After reset, `faultPulse` is 0 and `faultAddr` is 0.
- R2: A fault can only be raised while both `flagAlign` and `ctrlAlignMask` are 1. If either one is 0, no access faults.
- R3: A fault can only be raised when `accCpl` equals 3. Levels 0, 1 and 2 never fault.
- R4: With `accSize` = 1, which encodes a 2-byte operand, an access faults when address bit 0 is 1.
- R5: With `accSize` = 2, which encodes a 4-byte operand, an access faults when address bits [1:0] are not both zero.
- R6: With `accSize` = 3, which encodes an 8-byte operand, an access faults when address bits [2:0] are not all zero.
- R7: With `accSize` = 0, which encodes a single byte, an access never faults.
- R8: An access with `accImplicitSup` = 1 never faults, even when `accCpl` is 3.
- R9: When `accValid` is 0, no fault is raised, whatever the other inputs are.
- R10: A faulting access presented before a rising edge makes `faultPulse` high for exactly the cycle after that edge. In that same cycle `faultAddr` shows the access address. `faultAddr` then holds its value until the next fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| accValid | input | 1 | The access inputs carry a valid access this cycle |
| accAddr | input | ADDR_W | Linear address of the access |
| accSize | input | 2 | Operand size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes |
| accCpl | input | 2 | Privilege level of the access |
| accImplicitSup | input | 1 | Access is performed implicitly at the most privileged level |
| flagAlign | input | 1 | Alignment enable bit from the flags register |
| ctrlAlignMask | input | 1 | Alignment mask enable bit from the control register |
| faultPulse | output | 1 | One-cycle alignment fault pulse |
| faultAddr | output | ADDR_W | Address of the most recent faulting access |

## Verification
Two things can happen in the same cycle: the fault pulse for one access, and the capture of a fault for the very next access. The bench provokes this by issuing two misaligned user accesses on consecutive cycles. The scoreboard then requires `faultPulse` to stay high for both cycles, with `faultAddr` moving from the first address to the second. It also requires the second address to survive the idle cycles that follow.

// File: rtl/align_guard_pkg.sv
package align_guard_pkg;

  localparam int SIZE_W   = 2;
  localparam int CPL_W    = 2;
  localparam int LOW_BITS = 3;
  localparam logic [CPL_W-1:0] USER_CPL = 2'd3;

  typedef struct packed {
    logic capture;
  } guardStrobes_t;

  // For each size code, the low address bits that must all be zero.
  function automatic logic [LOW_BITS-1:0] sizeMask(input logic [SIZE_W-1:0] sizeCode);
    logic [LOW_BITS-1:0] mask;
    for (int i = 0; i < LOW_BITS; i++) begin
      mask[i] = (int'(sizeCode) > i);
    end
    return mask;
  endfunction

endpackage

// File: rtl/align_guard_ctrl.sv
module align_guard_ctrl
  import align_guard_pkg::*;
(
  input  logic                accValid,
  input  logic [LOW_BITS-1:0] addrLow,
  input  logic [SIZE_W-1:0]   accSize,
  input  logic [CPL_W-1:0]    accCpl,
  input  logic                accImplicitSup,
  input  logic                flagAlign,
  input  logic                ctrlAlignMask,
  output guardStrobes_t       strobes
);

  logic checkEnabled;
  logic userAccess;
  logic misaligned;

  always_comb begin
    checkEnabled    = flagAlign && ctrlAlignMask;
    userAccess      = (accCpl == USER_CPL) && !accImplicitSup;
    misaligned      = |(addrLow & sizeMask(accSize));
    strobes.capture = accValid && checkEnabled && userAccess && misaligned;
  end

endmodule

// File: rtl/align_guard_dp.sv
module align_guard_dp
  import align_guard_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  guardStrobes_t     strobes,
  input  logic [ADDR_W-1:0] accAddr,
  output logic              faultPulse,
  output logic [ADDR_W-1:0] faultAddr
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultPulse <= 1'b0;
      faultAddr  <= '0;
    end else begin
      faultPulse <= strobes.capture;
      if (strobes.capture) begin
        faultAddr <= accAddr;
      end
    end
  end

endmodule

// File: rtl/align_guard.sv
module align_guard
  import align_guard_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [1:0]        accSize,
  input  logic [1:0]        accCpl,
  input  logic              accImplicitSup,
  input  logic              flagAlign,
  input  logic              ctrlAlignMask,
  output logic              faultPulse,
  output logic [ADDR_W-1:0] faultAddr
);

  guardStrobes_t strobes;

  align_guard_ctrl u_ctrl (
    .accValid       (accValid),
    .addrLow        (accAddr[LOW_BITS-1:0]),
    .accSize        (accSize),
    .accCpl         (accCpl),
    .accImplicitSup (accImplicitSup),
    .flagAlign      (flagAlign),
    .ctrlAlignMask  (ctrlAlignMask),
    .strobes        (strobes)
  );

  align_guard_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .accAddr    (accAddr),
    .faultPulse (faultPulse),
    .faultAddr  (faultAddr)
  );

endmodule

// File: rtl/align_guard_chk.sv
module align_guard_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic [ADDR_W-1:0] accAddr,
  input logic [1:0]        accSize,
  input logic [1:0]        accCpl,
  input logic              accImplicitSup,
  input logic              flagAlign,
  input logic              ctrlAlignMask,
  input logic              faultPulse,
  input logic [ADDR_W-1:0] faultAddr
);

  p_needs_enables_r2: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> $past(flagAlign && ctrlAlignMask));

  p_user_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> ($past(accCpl) == 2'd3));

  p_byte_never_r7: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> ($past(accSize) != 2'd0));

  p_implicit_exempt_r8: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> !$past(accImplicitSup));

  p_valid_needed_r9: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> $past(accValid));

  p_addr_capture_r10: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> (faultAddr == $past(accAddr)));

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !faultPulse |-> $stable(faultAddr));

endmodule

bind align_guard align_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .accValid       (accValid),
  .accAddr        (accAddr),
  .accSize        (accSize),
  .accCpl         (accCpl),
  .accImplicitSup (accImplicitSup),
  .flagAlign      (flagAlign),
  .ctrlAlignMask  (ctrlAlignMask),
  .faultPulse     (faultPulse),
  .faultAddr      (faultAddr)
);

// File: tb/align_guard_test.sv
module align_guard_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int WATCHDOG   = 5000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              accValid = 1'b0;
  logic [ADDR_W-1:0] accAddr = '0;
  logic [1:0]        accSize = '0;
  logic [1:0]        accCpl = '0;
  logic              accImplicitSup = 1'b0;
  logic              flagAlign = 1'b0;
  logic              ctrlAlignMask = 1'b0;
  logic              faultPulse;
  logic [ADDR_W-1:0] faultAddr;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  logic              expFaultQ[$];
  logic [ADDR_W-1:0] expAddrQ[$];
  string             tagQ[$];
  logic [ADDR_W-1:0] modelAddr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  align_guard #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accAddr(accAddr),
    .accSize(accSize), .accCpl(accCpl), .accImplicitSup(accImplicitSup),
    .flagAlign(flagAlign), .ctrlAlignMask(ctrlAlignMask),
    .faultPulse(faultPulse), .faultAddr(faultAddr)
  );

  // Driver: presents one access per cycle and pushes the expected result.
  task automatic access(input logic v, input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                        input logic [1:0] cpl, input logic imp, input logic fa,
                        input logic am, input string tag);
    logic bad_align;
    logic expFault;
    @(negedge clk);
    accValid = v; accAddr = a; accSize = sz; accCpl = cpl;
    accImplicitSup = imp; flagAlign = fa; ctrlAlignMask = am;
    case (sz)
      2'd0: bad_align = 1'b0;
      2'd1: bad_align = a[0];
      2'd2: bad_align = |a[1:0];
      default: bad_align = |a[2:0];
    endcase
    expFault = v && fa && am && (cpl == 2'd3) && !imp && bad_align;
    if (expFault) modelAddr = a;
    expFaultQ.push_back(expFault);
    expAddrQ.push_back(modelAddr);
    tagQ.push_back(tag);
  endtask

  // Monitor: compares the registered outputs just after each edge.
  always @(posedge clk) begin
    #1;
    if (expFaultQ.size() > 0) begin
      logic ef;
      logic [ADDR_W-1:0] ea;
      string t;
      ef = expFaultQ.pop_front();
      ea = expAddrQ.pop_front();
      t  = tagQ.pop_front();
      total++;
      if (faultPulse !== ef || faultAddr !== ea) begin
        bad++;
        $display("FAIL %s: faultPulse=%0b faultAddr=%h expected faultPulse=%0b faultAddr=%h",
                 t, faultPulse, faultAddr, ef, ea);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (faultPulse !== 1'b0 || faultAddr !== '0) begin
      bad++;
      $display("FAIL R1: faultPulse=%0b faultAddr=%h expected 0 and 0", faultPulse, faultAddr);
    end
    rstN = 1'b1;
    // R4: 2-byte operands
    access(1, 32'h0000_1001, 2'd1, 2'd3, 0, 1, 1, "R4 odd 2-byte");
    access(1, 32'h0000_1002, 2'd1, 2'd3, 0, 1, 1, "R4 even 2-byte");
    // R5: 4-byte operands
    access(1, 32'h0000_2002, 2'd2, 2'd3, 0, 1, 1, "R5 addr%4==2");
    access(1, 32'h0000_2004, 2'd2, 2'd3, 0, 1, 1, "R5 aligned");
    access(1, 32'h0000_2001, 2'd2, 2'd3, 0, 1, 1, "R5 addr%4==1");
    // R6: 8-byte operands
    access(1, 32'h0000_3004, 2'd3, 2'd3, 0, 1, 1, "R6 addr%8==4");
    access(1, 32'h0000_3008, 2'd3, 2'd3, 0, 1, 1, "R6 aligned");
    // R7: bytes never fault
    access(1, 32'h0000_4003, 2'd0, 2'd3, 0, 1, 1, "R7 byte");
    // R2: either enable clear
    access(1, 32'h0000_5001, 2'd1, 2'd3, 0, 0, 1, "R2 flag clear");
    access(1, 32'h0000_5003, 2'd2, 2'd3, 0, 1, 0, "R2 mask clear");
    // R3: non-user levels
    for (int lvl = 0; lvl < 3; lvl++) begin
      access(1, 32'h0000_6007, 2'd3, 2'(lvl), 0, 1, 1, "R3 supervisor level");
    end
    // R8: implicit supervisor access from user code
    access(1, 32'h0000_7001, 2'd2, 2'd3, 1, 1, 1, "R8 implicit");
    // R9: strobe low
    access(0, 32'h0000_8001, 2'd3, 2'd3, 0, 1, 1, "R9 invalid");
    // R10: back-to-back faults, then hold
    access(1, 32'h0000_9001, 2'd1, 2'd3, 0, 1, 1, "R10 first fault");
    access(1, 32'h0000_A003, 2'd3, 2'd3, 0, 1, 1, "R10 second fault");
    access(0, 32'h0000_0000, 2'd0, 2'd0, 0, 0, 0, "R10 hold");
    access(1, 32'h0000_B000, 2'd3, 2'd3, 0, 1, 1, "R10 hold aligned");
    access(0, 32'h0000_0000, 2'd0, 2'd0, 0, 0, 0, "R10 idle");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule